// File: doc/BRIEF.md
# Binary to Residue Forward Converter

This block turns an unsigned binary integer of 3n bits into its residue form over the three moduli 2^n-1, 2^n and 2^n+1. The input word is cut into three n-bit slices: a high slice H (bits 3n-1..2n), a middle slice M (bits 2n-1..n) and a low slice L (bits n-1..0). The input therefore equals H·2^(2n) + M·2^n + L. Because 2^n is congruent to 1 modulo 2^n-1 and to -1 modulo 2^n+1, each residue comes from a short sum of the slices. No divider and no lookup table is used.

The converter sits at the entry of a residue-arithmetic datapath. A source presents a word together with a valid strobe. One clock later the three residues appear with their own valid strobe. Between valid words the residue registers keep their last value. The slice width n is a parameter, and both n=2 (moduli 3, 4, 5) and n=3 (moduli 7, 8, 9) are supported.

Top module: `rns_fwd_conv`

## Requirements
- R1: The input word is 3n bits wide. Bits 3n-1..2n form the high slice H, bits 2n-1..n form the middle slice M, and bits n-1..0 form the low slice L.
- R2: `res_mid` (n bits) equals the input modulo 2^n, which is the low slice L passed through unchanged.
- R3: `res_lo` (n bits) equals the input modulo 2^n-1, formed as (H+M+L) reduced with end-around carry. It is always in 0..2^n-2; an all-ones sum is output as 0.
- R4: `res_hi` (n+1 bits) equals the input modulo 2^n+1, formed as (H-M+L) brought into the range 0..2^n.
- R5: While `rst_n` is low, `out_valid` and all residue outputs are 0.
- R6: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was high. Results appear one clock after the accepted input.
- R7: In a cycle where `in_valid` is low, the residue outputs keep their previous values on the next cycle, whatever `in_data` carries.
- R8: The same design gives correct residues for n=2 (moduli 3, 4, 5) and n=3 (moduli 7, 8, 9).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word is present this cycle |
| in_data | input | 3N | Unsigned binary input word |
| out_valid | output | 1 | Residues are fresh this cycle |
| res_lo | output | N | Residue modulo 2^N-1 |
| res_mid | output | N | Residue modulo 2^N |
| res_hi | output | N+1 | Residue modulo 2^N+1 |

## Verification
The bench sweeps every input value for both n=2 and n=3 and compares each result with a plain modulo computed in the bench. The sweep covers words where one slice alone is nonzero, which separates a wrong field cut from a wrong fold. It also covers words whose H+M+L sum hits 2^n-1 or a multiple of it, which exposes a missing all-ones-to-zero mapping, and words with M larger than H+L, which exposes a missing negative correction on the 2^n+1 path. Separate scenarios hold `in_valid` low while `in_data` changes, to show that the outputs hold, and they check the strobe latency and the reset state.

// File: rtl/rns_fwd_pkg.sv
package rns_fwd_pkg;

    // Smallest and largest slice widths the converter is meant for.
    localparam int unsigned RNS_N_MIN = 2;
    localparam int unsigned RNS_N_MAX = 8;

    // Modulus values for a given slice width.
    function automatic int unsigned mod_below(input int unsigned n);
        return (32'd1 << n) - 32'd1;
    endfunction

    function automatic int unsigned mod_above(input int unsigned n);
        return (32'd1 << n) + 32'd1;
    endfunction

endpackage

// File: rtl/rns_fold_below.sv
// Residue modulo 2^N-1: slices are summed and folded with end-around carry.
module rns_fold_below #(
    parameter int unsigned N = 3
) (
    input  logic [N-1:0] slice_h,
    input  logic [N-1:0] slice_m,
    input  logic [N-1:0] slice_l,
    output logic [N-1:0] residue
);
    localparam int unsigned SW = N + 2;   // width of a three-slice sum

    logic [SW-1:0] sum3;
    logic [N:0]    fold1;
    logic [N-1:0]  fold2;

    always_comb begin
        sum3    = {2'b00, slice_h} + {2'b00, slice_m} + {2'b00, slice_l};
        // weight of bits above N is 1 modulo 2^N-1
        fold1   = {1'b0, sum3[N-1:0]} + {{(N-1){1'b0}}, sum3[SW-1:N]};
        fold2   = fold1[N-1:0] + {{(N-1){1'b0}}, fold1[N]};
        // all-ones is the second encoding of zero
        residue = (&fold2) ? '0 : fold2;
    end
endmodule

// File: rtl/rns_fold_above.sv
// Residue modulo 2^N+1: H - M + L, biased by the modulus to stay non-negative.
module rns_fold_above #(
    parameter int unsigned N = 3
) (
    input  logic [N-1:0] slice_h,
    input  logic [N-1:0] slice_m,
    input  logic [N-1:0] slice_l,
    output logic [N:0]   residue
);
    localparam int unsigned        UW  = N + 2;
    localparam logic [UW-1:0]      MOD = UW'((1 << N) + 1);

    logic [UW-1:0] biased;
    logic [UW-1:0] step1;
    logic [UW-1:0] step2;

    always_comb begin
        // adding the modulus turns a negative H-M+L into its positive class
        biased  = {2'b00, slice_h} + {2'b00, slice_l} + (MOD - {2'b00, slice_m});
        step1   = (biased >= MOD) ? biased - MOD : biased;
        step2   = (step1  >= MOD) ? step1  - MOD : step1;
        residue = step2[N:0];
    end
endmodule

// File: rtl/rns_fwd_conv.sv
module rns_fwd_conv
    import rns_fwd_pkg::*;
#(
    parameter int unsigned N = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [3*N-1:0]  in_data,
    output logic            out_valid,
    output logic [N-1:0]    res_lo,
    output logic [N-1:0]    res_mid,
    output logic [N:0]      res_hi
);
    localparam int unsigned W = 3 * N;

    typedef struct packed {
        logic         vld;
        logic [N-1:0] lo;
        logic [N-1:0] mid;
        logic [N:0]   hi;
    } conv_state_t;

    conv_state_t st_d, st_q;

    logic [N-1:0] slice_h, slice_m, slice_l;   // R1
    logic [N-1:0] lo_calc;
    logic [N:0]   hi_calc;

    assign slice_h = in_data[W-1:2*N];
    assign slice_m = in_data[2*N-1:N];
    assign slice_l = in_data[N-1:0];

    rns_fold_below #(.N(N)) i_fold_below (
        .slice_h (slice_h),
        .slice_m (slice_m),
        .slice_l (slice_l),
        .residue (lo_calc)
    );

    rns_fold_above #(.N(N)) i_fold_above (
        .slice_h (slice_h),
        .slice_m (slice_m),
        .slice_l (slice_l),
        .residue (hi_calc)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.lo  = lo_calc;
            st_d.mid = slice_l;
            st_d.hi  = hi_calc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign res_lo    = st_q.lo;
    assign res_mid   = st_q.mid;
    assign res_hi    = st_q.hi;

    initial begin
        if (N < RNS_N_MIN || N > RNS_N_MAX)
            $error("rns_fwd_conv: slice width out of range");
    end

    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);                                              // R6
    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);                                            // R6
    AST_MID_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (res_mid == $past(in_data[N-1:0])));                     // R2
    AST_LO_CANON: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (res_lo != {N{1'b1}}));                                 // R3
    AST_HI_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ({1'b0, res_hi} <= (N+2)'(mod_above(N) - 1)));          // R4
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(res_lo) && $stable(res_mid) && $stable(res_hi))); // R7
endmodule

// File: tb/test_rns_fwd_conv.sv
`timescale 1ns/1ps
module test_rns_fwd_conv;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;   // 200 MHz

    // n = 3 instance
    logic       v3_in = 1'b0;
    logic [8:0] d3_in = '0;
    logic       v3_out;
    logic [2:0] lo3, mid3;
    logic [3:0] hi3;

    // n = 2 instance
    logic       v2_in = 1'b0;
    logic [5:0] d2_in = '0;
    logic       v2_out;
    logic [1:0] lo2, mid2;
    logic [2:0] hi2;

    rns_fwd_conv #(.N(3)) i_rns_fwd_conv (
        .clk(clk), .rst_n(rst_n), .in_valid(v3_in), .in_data(d3_in),
        .out_valid(v3_out), .res_lo(lo3), .res_mid(mid3), .res_hi(hi3)
    );

    rns_fwd_conv #(.N(2)) i_rns_fwd_conv_n2 (
        .clk(clk), .rst_n(rst_n), .in_valid(v2_in), .in_data(d2_in),
        .out_valid(v2_out), .res_lo(lo2), .res_mid(mid2), .res_hi(hi2)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // R5: reset state
    task automatic t_reset();
        @(negedge clk);
        check("R5", "n3 out_valid", v3_out, 0);
        check("R5", "n3 res_lo",    lo3,    0);
        check("R5", "n3 res_mid",   mid3,   0);
        check("R5", "n3 res_hi",    hi3,    0);
        check("R5", "n2 out_valid", v2_out, 0);
        check("R5", "n2 res_hi",    hi2,    0);
    endtask

    // R1 R2 R3 R4 R8: every 9-bit word through the n = 3 converter
    task automatic t_sweep_n3();
        for (int x = 0; x < 512; x++) begin
            @(negedge clk);
            v3_in = 1'b1; d3_in = 9'(x);
            @(negedge clk);
            v3_in = 1'b0;
            check("R6", "n3 out_valid", v3_out, 1);
            check("R3", $sformatf("n3 mod7 of %0d", x), lo3,  x % 7);
            check("R2", $sformatf("n3 mod8 of %0d", x), mid3, x % 8);
            check("R4", $sformatf("n3 mod9 of %0d", x), hi3,  x % 9);
        end
    endtask

    // R8: every 6-bit word through the n = 2 converter
    task automatic t_sweep_n2();
        for (int x = 0; x < 64; x++) begin
            @(negedge clk);
            v2_in = 1'b1; d2_in = 6'(x);
            @(negedge clk);
            v2_in = 1'b0;
            check("R8", "n2 out_valid", v2_out, 1);
            check("R8", $sformatf("n2 mod3 of %0d", x), lo2,  x % 3);
            check("R8", $sformatf("n2 mod4 of %0d", x), mid2, x % 4);
            check("R8", $sformatf("n2 mod5 of %0d", x), hi2,  x % 5);
        end
    endtask

    // R1: single-slice words separate the slice cut from the fold
    task automatic t_slices();
        int words[3] = '{9'o700, 9'o070, 9'o007};
        foreach (words[i]) begin
            @(negedge clk);
            v3_in = 1'b1; d3_in = 9'(words[i]);
            @(negedge clk);
            v3_in = 1'b0;
            check("R1", $sformatf("slice word %0d mod7", words[i]), lo3, words[i] % 7);
            check("R1", $sformatf("slice word %0d mod9", words[i]), hi3, words[i] % 9);
        end
    endtask

    // R6 R7: idle inputs change nothing, strobe falls after one cycle
    task automatic t_hold();
        @(negedge clk);
        v3_in = 1'b1; d3_in = 9'd300;      // 300 mod 7=6, mod 8=4, mod 9=3
        @(negedge clk);
        v3_in = 1'b0; d3_in = 9'd511;
        @(negedge clk);
        check("R6", "strobe after idle", v3_out, 0);
        for (int k = 0; k < 4; k++) begin
            d3_in = 9'(k * 97 + 5);
            @(negedge clk);
            check("R7", "held res_lo",  lo3,  6);
            check("R7", "held res_mid", mid3, 4);
            check("R7", "held res_hi",  hi3,  3);
            check("R6", "idle strobe",  v3_out, 0);
        end
    endtask

    // R6: back-to-back words each land one cycle later
    task automatic t_stream();
        @(negedge clk);
        v3_in = 1'b1; d3_in = 9'd511;
        @(negedge clk);
        check("R6", "stream 1 strobe", v3_out, 1);
        check("R3", "all-ones word mod7", lo3, 0);
        d3_in = 9'd56;
        @(negedge clk);
        v3_in = 1'b0;
        check("R6", "stream 2 strobe", v3_out, 1);
        check("R4", "word 56 mod9", hi3, 2);
        check("R2", "word 56 mod8", mid3, 0);
        @(negedge clk);
        check("R6", "stream end strobe", v3_out, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_sweep_n3();
        t_sweep_n2();
        t_slices();
        t_hold();
        t_stream();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule